// File: doc/BRIEF.md
# Reset-counting pixel integration controller

This block is the digital side of a pixel that integrates detector charge without ever saturating. An external comparator reports, every clock, whether the analog integrator output has passed its threshold. Whenever the block accepts such a decision, it fires a reset pulse back to that pixel's integrator and adds one to the pixel's packet counter. Full-scale charge is therefore set by the counter width, not by the integrator capacitor.

A frame is driven by the surrounding timing logic. A one-cycle frame-start clears every counter, and a level window input marks the integration period. After the window closes, the block waits for every reset pulse still in flight to finish, then issues one sample strobe so the residual voltage can be captured. In the next cycle it copies each pixel's count and overflow flag into a result memory and raises a valid flag. A read address then selects which pixel's word appears on the read port.

Several pixels share one sequencer and one result memory. Each pixel keeps its own counter, reset timer and comparator blanking.

Top module: `charge_packet_ctrl`

## Requirements
- R1: After the reset input is released, every integrator reset output, the sample strobe and the valid flag are low, and the read port returns count 0 with overflow 0 for every pixel address.
- R2: A comparator decision that is accepted drives that pixel's reset output high from the next cycle for exactly `rst_len_i` cycles. A value of 0 on `rst_len_i` is treated as 1.
- R3: Each accepted decision adds one to that pixel's count, and the stored count equals the number of accepted decisions in the frame.
- R4: A pixel ignores its comparator for as long as its reset output is high, and also for the single cycle after the reset output falls.
- R5: The count stops at 2^CNT_W-1. An accepted decision that arrives when the count is already at that value still issues a reset pulse and sets the pixel's sticky overflow flag. A frame with exactly 2^CNT_W-1 accepted decisions leaves the flag at 0.
- R6: Comparator decisions are ignored outside the integration window: between frame-start and the first open window cycle, after the window closes, and between frames.
- R7: A decision accepted in the last open window cycle is counted and its full reset pulse is issued. The sample strobe is a one-cycle pulse that comes two clock edges after the later of two points: the last edge at which the window is sampled open, and the last edge after which any reset output is high. No reset output is high while the strobe is high.
- R8: The valid flag rises in the cycle after the sample strobe. From then on, `rd_addr_i` = p returns pixel p's count on `rd_count_o` and its overflow flag on `rd_ovf_o`, and the flag stays high until the next frame-start.
- R9: Frame-start clears every counter and overflow flag and lowers the valid flag from the next cycle, so counts never carry from one frame into the next.
- R10: Pixels are independent. One pixel's decisions, resets and saturation do not change another pixel's count, flag or reset output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | One-cycle frame start; clears counters and valid |
| win_i | input | 1 | Integration window, high while charge is integrated |
| rst_len_i | input | RL_W | Reset pulse length in cycles (0 acts as 1) |
| comp_i | input | NPIX | Per-pixel comparator decision, high when over threshold |
| int_rst_o | output | NPIX | Per-pixel integrator reset pulse |
| sample_o | output | 1 | One-cycle sample-and-hold strobe for the residue |
| valid_o | output | 1 | Result memory holds the finished frame |
| rd_addr_i | input | AW | Pixel index to read |
| rd_count_o | output | CNT_W | Stored packet count of the addressed pixel |
| rd_ovf_o | output | 1 | Stored overflow flag of the addressed pixel |

## Verification
The bench builds the block with four pixels, a 3-bit reset length and a 4-bit counter. With that narrow counter, a comparator held high over a long window reaches the saturation limit of 15 and goes past it in a few dozen cycles, and a second pixel lands exactly on 15, so both sides of the overflow boundary are covered. The 3-bit length field covers reset lengths of 0 (treated as 1), 2 and 5. Windows whose last cycle carries a crossing show how the sample strobe is pushed back by a long reset.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_WAIT   = 3'd1,
        SEQ_INTEG  = 3'd2,
        SEQ_DRAIN  = 3'd3,
        SEQ_SAMPLE = 3'd4
    } seq_state_e;

endpackage

// File: rtl/cpc_pixel.sv
module cpc_pixel #(
    parameter int CNT_W = 12,
    parameter int RL_W  = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             open_i,
    input  logic             comp_i,
    input  logic [RL_W-1:0]  len_i,
    output logic             int_rst_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [RL_W-1:0]  LEN_ONE = RL_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic [RL_W-1:0]  hold;
        logic             guard;
    } pix_t;

    pix_t            st_d, st_q;
    logic [RL_W-1:0] len_eff;

    always_comb begin
        len_eff = (len_i == '0) ? LEN_ONE : len_i;
        st_d    = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (st_q.hold != '0) begin
            // reset pulse in progress: decisions are blanked
            st_d.hold  = st_q.hold - LEN_ONE;
            st_d.guard = (st_q.hold == LEN_ONE);
        end else if (st_q.guard) begin
            // settling cycle after the pulse: still blanked
            st_d.guard = 1'b0;
        end else if (open_i && comp_i) begin
            st_d.hold = len_eff;
            if (st_q.cnt == CNT_MAX) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_rst_o = (st_q.hold != '0);
    assign count_o   = st_q.cnt;
    assign ovf_o     = st_q.ovf;

endmodule

// File: rtl/cpc_seq.sv
module cpc_seq
    import cpc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic frame_start_i,
    input  logic win_i,
    input  logic busy_i,
    output logic open_o,
    output logic clear_o,
    output logic sample_o,
    output logic store_o,
    output logic valid_o
);

    typedef struct packed {
        seq_state_e state;
        logic       valid;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start_i) begin
            st_d.state = SEQ_WAIT;
            st_d.valid = 1'b0;
        end else begin
            unique case (st_q.state)
                SEQ_WAIT:   if (win_i)   st_d.state = SEQ_INTEG;
                SEQ_INTEG:  if (!win_i)  st_d.state = SEQ_DRAIN;
                SEQ_DRAIN:  if (!busy_i) st_d.state = SEQ_SAMPLE;
                SEQ_SAMPLE: begin
                    st_d.state = SEQ_IDLE;
                    st_d.valid = 1'b1;
                end
                default:    st_d.state = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{state: SEQ_IDLE, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o   = win_i && ((st_q.state == SEQ_WAIT) || (st_q.state == SEQ_INTEG));
    assign clear_o  = frame_start_i;
    assign sample_o = (st_q.state == SEQ_SAMPLE);
    assign store_o  = (st_q.state == SEQ_SAMPLE) && !frame_start_i;
    assign valid_o  = st_q.valid;

endmodule

// File: rtl/cpc_store.sv
module cpc_store #(
    parameter int NPIX  = 4,
    parameter int CNT_W = 12,
    parameter int AW    = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_i,
    input  logic [NPIX*CNT_W-1:0] cnt_i,
    input  logic [NPIX-1:0]       ovf_i,
    input  logic [AW-1:0]         rd_addr_i,
    output logic [CNT_W-1:0]      rd_count_o,
    output logic                  rd_ovf_o
);

    typedef struct packed {
        logic             ovf;
        logic [CNT_W-1:0] cnt;
    } word_t;

    word_t mem_d [NPIX];
    word_t mem_q [NPIX];
    word_t rd_word;

    always_comb begin
        for (int p = 0; p < NPIX; p++) begin
            mem_d[p] = mem_q[p];
            if (wr_i) begin
                mem_d[p] = '{ovf: ovf_i[p], cnt: cnt_i[p*CNT_W +: CNT_W]};
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int p = 0; p < NPIX; p++) begin
                mem_q[p] <= '0;
            end
        end else begin
            for (int p = 0; p < NPIX; p++) begin
                mem_q[p] <= mem_d[p];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (int'(rd_addr_i) < NPIX) begin
            rd_word = mem_q[rd_addr_i];
        end
    end

    assign rd_count_o = rd_word.cnt;
    assign rd_ovf_o   = rd_word.ovf;

endmodule

// File: rtl/charge_packet_ctrl.sv
module charge_packet_ctrl #(
    parameter int  NPIX  = 4,
    parameter int  CNT_W = 12,
    parameter int  RL_W  = 3,
    localparam int AW    = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             frame_start_i,
    input  logic             win_i,
    input  logic [RL_W-1:0]  rst_len_i,
    input  logic [NPIX-1:0]  comp_i,
    output logic [NPIX-1:0]  int_rst_o,
    output logic             sample_o,
    output logic             valid_o,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [CNT_W-1:0] rd_count_o,
    output logic             rd_ovf_o
);

    logic                  open;
    logic                  clear;
    logic                  store;
    logic                  busy;
    logic [NPIX*CNT_W-1:0] cnt_flat;
    logic [NPIX-1:0]       ovf_vec;

    assign busy = |int_rst_o;

    cpc_seq u_seq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .frame_start_i (frame_start_i),
        .win_i         (win_i),
        .busy_i        (busy),
        .open_o        (open),
        .clear_o       (clear),
        .sample_o      (sample_o),
        .store_o       (store),
        .valid_o       (valid_o)
    );

    for (genvar g = 0; g < NPIX; g++) begin : g_pix
        cpc_pixel #(
            .CNT_W (CNT_W),
            .RL_W  (RL_W)
        ) u_pix (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .clear_i   (clear),
            .open_i    (open),
            .comp_i    (comp_i[g]),
            .len_i     (rst_len_i),
            .int_rst_o (int_rst_o[g]),
            .count_o   (cnt_flat[g*CNT_W +: CNT_W]),
            .ovf_o     (ovf_vec[g])
        );
    end

    cpc_store #(
        .NPIX  (NPIX),
        .CNT_W (CNT_W),
        .AW    (AW)
    ) u_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (store),
        .cnt_i      (cnt_flat),
        .ovf_i      (ovf_vec),
        .rd_addr_i  (rd_addr_i),
        .rd_count_o (rd_count_o),
        .rd_ovf_o   (rd_ovf_o)
    );

endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
    parameter int NPIX = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            frame_start_i,
    input logic            win_i,
    input logic [NPIX-1:0] int_rst_o,
    input logic            sample_o,
    input logic            valid_o
);

    assert_sample_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |=> !sample_o);

    assert_sample_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> (int_rst_o == '0));

    assert_valid_after_sample_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_o && !frame_start_i) |=> valid_o);

    assert_valid_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(valid_o) |-> $past(sample_o));

    assert_valid_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_i |=> !valid_o);

    assert_closed_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!win_i && (int_rst_o == '0)) |=> (int_rst_o == '0));

    for (genvar g = 0; g < NPIX; g++) begin : g_chk
        assert_blank_after_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(int_rst_o[g]) |=> !int_rst_o[g]);
    end

endmodule

bind charge_packet_ctrl cpc_checker #(.NPIX(NPIX)) u_cpc_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .win_i         (win_i),
    .int_rst_o     (int_rst_o),
    .sample_o      (sample_o),
    .valid_o       (valid_o)
);

// File: tb/sim_charge_packet_ctrl.sv
module sim_charge_packet_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NPIX  = 4;
    localparam int CNT_W = 4;
    localparam int RL_W  = 3;
    localparam int AW    = 2;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_ni = 1'b0;
    logic             frame_start = 1'b0;
    logic             win = 1'b0;
    logic [RL_W-1:0]  rst_len = '0;
    logic [NPIX-1:0]  comp = '0;
    logic [NPIX-1:0]  int_rst;
    logic             sample;
    logic             valid;
    logic [AW-1:0]    rd_addr = '0;
    logic [CNT_W-1:0] rd_count;
    logic             rd_ovf;

    int checks = 0;
    int failures = 0;

    typedef struct {
        int pix;
        int cnt;
        bit ovf;
    } exp_t;
    exp_t sb_q[$];

    bit ev_g [NPIX][64];
    int acc_g [NPIX];

    always #(CLK_PERIOD/2) clk = ~clk;

    charge_packet_ctrl #(.NPIX(NPIX), .CNT_W(CNT_W), .RL_W(RL_W)) u0 (
        .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start), .win_i(win),
        .rst_len_i(rst_len), .comp_i(comp), .int_rst_o(int_rst), .sample_o(sample),
        .valid_o(valid), .rd_addr_i(rd_addr), .rd_count_o(rd_count), .rd_ovf_o(rd_ovf)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic clear_ev();
        for (int p = 0; p < NPIX; p++) begin
            acc_g[p] = 0;
            for (int i = 0; i < 64; i++) ev_g[p][i] = 1'b0;
        end
    endtask

    task automatic set_range(input int p, input int a, input int b);
        for (int i = a; i <= b; i++) ev_g[p][i] = 1'b1;
    endtask

    // Driver: runs one frame, pushes expected stored words, checks timing at the ports.
    task automatic run_frame(input int len, input int w, input int exp_k);
        int hi [NPIX];
        int leff;
        int got_k;
        leff = (len == 0) ? 1 : len;
        for (int p = 0; p < NPIX; p++) begin
            hi[p] = 0;
            sb_q.push_back('{pix: p,
                             cnt: (acc_g[p] > CMAX) ? CMAX : acc_g[p],
                             ovf: (acc_g[p] > CMAX)});
        end
        @(negedge clk);
        rst_len = RL_W'(len);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check(valid == 1'b0, "R9", "valid after frame start", int'(valid), 0);
        comp = '1;  // window not open yet: must be ignored
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(int_rst == '0, "R6", "reset before window", int'(int_rst), 0);
        end
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            for (int p = 0; p < NPIX; p++) hi[p] += int'(int_rst[p]);
            win = 1'b1;
            for (int p = 0; p < NPIX; p++) comp[p] = ev_g[p][i];
        end
        @(negedge clk);
        for (int p = 0; p < NPIX; p++) hi[p] += int'(int_rst[p]);
        win = 1'b0;
        comp = '1;  // window closed: must be ignored (R6)
        got_k = -1;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            for (int p = 0; p < NPIX; p++) hi[p] += int'(int_rst[p]);
            if (sample) begin
                got_k = k;
                check(int_rst == '0, "R7", "reset during sample", int'(int_rst), 0);
                break;
            end
        end
        check(got_k == exp_k, "R7", "sample strobe delay", got_k, exp_k);
        @(negedge clk);
        for (int p = 0; p < NPIX; p++) hi[p] += int'(int_rst[p]);
        check(sample == 1'b0, "R7", "sample width", int'(sample), 0);
        check(valid == 1'b1, "R8", "valid after sample", int'(valid), 1);
        for (int p = 0; p < NPIX; p++) begin
            check(hi[p] == acc_g[p] * leff, "R2", $sformatf("reset cycles pix%0d", p),
                  hi[p], acc_g[p] * leff);
        end
        comp = '0;
        repeat (4) @(negedge clk);
    endtask

    // Monitor: on each finished frame, read every pixel word and compare with the queue.
    initial begin
        forever begin
            @(posedge valid);
            @(negedge clk);
            for (int p = 0; p < NPIX; p++) begin
                exp_t e;
                rd_addr = AW'(p);
                #1;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3", "scoreboard empty", p, -1);
                end else begin
                    e = sb_q.pop_front();
                    check(int'(rd_count) == e.cnt, "R3",
                          $sformatf("count pix%0d", e.pix), int'(rd_count), e.cnt);
                    check(rd_ovf == e.ovf, "R5",
                          $sformatf("overflow pix%0d", e.pix), int'(rd_ovf), int'(e.ovf));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog: got 0 expected 1 (run did not end)");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(int_rst == '0, "R1", "reset outputs", int'(int_rst), 0);
        check(sample == 1'b0, "R1", "sample", int'(sample), 0);
        check(valid == 1'b0, "R1", "valid", int'(valid), 0);
        for (int p = 0; p < NPIX; p++) begin
            rd_addr = AW'(p);
            #1;
            check(rd_count == '0 && rd_ovf == 1'b0, "R1", "memory word",
                  int'({rd_ovf, rd_count}), 0);
        end

        // Frame 1, length 2: spaced crossings (R3), held comparator (R4),
        // crossing in last window cycle (R7), silent pixel (R6)
        clear_ev();
        ev_g[0][0] = 1'b1; ev_g[0][10] = 1'b1; ev_g[0][20] = 1'b1; acc_g[0] = 3;
        acc_g[1] = 0;
        ev_g[2][39] = 1'b1; acc_g[2] = 1;
        set_range(3, 5, 12); acc_g[3] = 2;
        run_frame(2, 40, 3);

        // Frame 2, length 0 acts as 1 (R2); counts restart (R9)
        clear_ev();
        set_range(0, 0, 39); acc_g[0] = 14;
        ev_g[1][0] = 1'b1; ev_g[1][2] = 1'b1; acc_g[1] = 1;
        acc_g[2] = 0;
        ev_g[3][10] = 1'b1; ev_g[3][13] = 1'b1; acc_g[3] = 2;
        run_frame(0, 40, 2);

        // Frame 3: saturation past the limit and exactly at it (R5), independence (R10)
        clear_ev();
        set_range(0, 0, 59); acc_g[0] = 20;
        ev_g[1][0] = 1'b1; ev_g[1][30] = 1'b1; acc_g[1] = 2;
        acc_g[2] = 0;
        set_range(3, 0, 44); acc_g[3] = 15;
        run_frame(0, 60, 2);

        // Frame 4, length 5: long pulse delays the strobe (R7), blanking (R4), R10
        clear_ev();
        ev_g[0][2] = 1'b1; acc_g[0] = 1;
        ev_g[1][19] = 1'b1; acc_g[1] = 1;
        ev_g[2][19] = 1'b1; acc_g[2] = 1;
        set_range(3, 0, 19); acc_g[3] = 3;
        run_frame(5, 20, 6);

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R8", "all frames read back", sb_q.size(), 0);
        summary();
        $finish;
    end

endmodule